// File: doc/BRIEF.md
# Serial Programming-Mode Entry Sequencer

This block sits on the programmer side of a serial programming link. Its job is to bring an attached target into its serial programming mode. After its own reset it holds the target reset line and the serial clock low. When `start` is pulsed, it begins an attempt. Each attempt raises the target reset line for a set number of cycles and then waits a settling interval, which is long enough to cover the target's power-up time. It then shifts a fixed four-byte enable command out through a built-in SPI master. The length of each serial clock phase is a parameter.

During the transfer the block also shifts in the byte the target returns. The byte that arrives during one chosen transfer, the third one by default, is compared with the expected echo value. If they match, the block raises `done`, leaves the target reset line low and stops. If they do not match, the block starts a new attempt with a fresh reset pulse. After a set number of failed attempts it raises `fail` instead.

All durations are parameters counted in cycles of the host clock: the reset pulse width, the settling wait and the half period of the serial clock. To meet a wait of 20 ms, set the settling parameter to 20 ms divided by the host clock period. The command bytes, the index of the echo byte, the echo value, the retry limit and the bit order are also parameters.

Top module: `pe_enable_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `tgt_reset`, `sck`, `mosi`, `busy`, `done` and `fail` are all 0.
- R2: When `start` is high in a cycle where the block is not busy, `tgt_reset` is 1 for exactly RST_PULSE_CYC cycles, starting the next cycle. During those cycles `sck` and `mosi` are 0.
- R3: After the reset pulse, `tgt_reset`, `sck` and `mosi` stay 0 for SETTLE_CYC cycles. The first bit's low phase then follows, so the first rising `sck` edge comes SETTLE_CYC+HALF_CYC cycles after `tgt_reset` falls.
- R4: Every attempt shifts out all four command bytes, 32 `sck` pulses in total, whatever the echo turns out to be. The default command is 0xAC, 0x53, 0x00, 0x00, sent in that order with the most significant bit of each byte first.
- R5: Each bit is presented on `mosi` for HALF_CYC cycles with `sck` low and then for HALF_CYC cycles with `sck` high. `mosi` only changes when `sck` falls. `miso` is sampled at the end of the low phase, which is after the previous falling edge and before the next rising edge.
- R6: The eight bits sampled during transfer number 2 (counting from 0, i.e. bits 15 down to 8 of the 32-bit reply stream) are compared with ECHO_VAL, which is 0x53 by default. The comparison happens in a single cycle, with `busy` high and `sck` low, right after the last bit of the attempt.
- R7: When the echo matches, `done` goes to 1 the next cycle and `busy` goes to 0. `done` stays at 1 and `tgt_reset` stays at 0 until the next accepted `start`.
- R8: When the echo does not match and fewer than MAX_TRIES attempts have been made, a new reset pulse starts the next cycle. After MAX_TRIES mismatches, `fail` goes to 1 and stays there until the next accepted `start`.
- R9: `start` is ignored while `busy` is 1. `start` is accepted when the block is idle or after it has finished with `done` or `fail`, and accepting it clears `done` and `fail`.
- R10: `busy` is 1 from the cycle after `start` is accepted until the end of the final comparison cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the entry sequence when not busy |
| miso | input | 1 | Serial data from the target |
| tgt_reset | output | 1 | Target reset line; 1 during the resync pulse |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Target answered with the expected echo |
| fail | output | 1 | Retry limit reached without a matching echo |

## Verification
The case that is hardest to reach from the ports is a retry followed by a success. It needs the target to give a wrong echo on one attempt and the correct echo on the next. The bench models the target: on each rising edge of `tgt_reset` it loads a new 32-bit reply word, and it shifts that word out one bit per falling edge of `sck`. Because the bench picks a word for each attempt, it can produce mismatch-then-match and mismatch on every attempt. It also raises `start` in the middle of a transfer to check that the request is ignored while busy.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_PULSE,
      PS_SETTLE,
      PS_XFER,
      PS_CHECK,
      PS_DONE,
      PS_FAIL
   } pe_state_e;

   function automatic int unsigned pe_max3(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/pe_phase_timer.sv
module pe_phase_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   // R3: the phase counter only moves down between loads
   a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/pe_bit_shifter.sv
module pe_bit_shifter #(
   parameter int unsigned NBYTES    = 4,
   parameter int unsigned BW        = 8,
   parameter int unsigned ECHO_IDX  = 2,
   parameter bit          LSB_FIRST = 1'b0,
   localparam int unsigned CMDW     = NBYTES * BW,
   localparam int unsigned BIW      = $clog2(BW),
   localparam int unsigned BYW      = $clog2(NBYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_i,
   input  logic            tick_i,
   input  logic            miso_i,
   input  logic [CMDW-1:0] cmd_i,
   output logic            sck_o,
   output logic            mosi_o,
   output logic            last_o,
   output logic [BW-1:0]   echo_o
);

   logic            act_q;
   logic            ph_q;
   logic [BIW-1:0]  bcnt_q;
   logic [BYW-1:0]  ycnt_q;
   logic [BW-1:0]   rx_q;
   logic [BW-1:0]   echo_q;
   logic [BW-1:0]   cur_byte;
   logic [CMDW-1:0] cmd_sh;
   logic            bit_sel;
   logic [BW-1:0]   rx_nxt;
   logic            last_bit;
   logic            last_byte;

   always_comb begin
      cmd_sh   = cmd_i << (int'(ycnt_q) * BW);
      cur_byte = cmd_sh[CMDW-1 -: BW];
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         assign bit_sel = cur_byte[bcnt_q];
         assign rx_nxt  = {miso_i, rx_q[BW-1:1]};
      end else begin : g_msb
         assign bit_sel = cur_byte[BIW'(BW-1) - bcnt_q];
         assign rx_nxt  = {rx_q[BW-2:0], miso_i};
      end
   endgenerate

   assign last_bit  = (bcnt_q == BIW'(BW-1));
   assign last_byte = (ycnt_q == BYW'(NBYTES-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         ph_q   <= 1'b0;
         bcnt_q <= '0;
         ycnt_q <= '0;
         rx_q   <= '0;
         echo_q <= '0;
      end else if (go_i) begin
         act_q  <= 1'b1;
         ph_q   <= 1'b0;
         bcnt_q <= '0;
         ycnt_q <= '0;
         rx_q   <= '0;
      end else if (tick_i && act_q) begin
         if (!ph_q) begin
            rx_q <= rx_nxt;
            ph_q <= 1'b1;
         end else begin
            ph_q <= 1'b0;
            if (last_bit) begin
               bcnt_q <= '0;
               if (ycnt_q == BYW'(ECHO_IDX)) echo_q <= rx_q;
               if (last_byte) act_q  <= 1'b0;
               else           ycnt_q <= ycnt_q + 1'b1;
            end else begin
               bcnt_q <= bcnt_q + 1'b1;
            end
         end
      end
   end

   assign sck_o  = act_q & ph_q;
   assign mosi_o = act_q & bit_sel;
   assign last_o = tick_i & act_q & ph_q & last_bit & last_byte;
   assign echo_o = echo_q;

   // R5: data is steady across every rising serial clock edge
   a_r5_mosi_stable_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_o) |-> $stable(mosi_o));

   // R4: a finished transfer leaves the clock low
   a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !sck_o);

endmodule

// File: rtl/pe_enable_seq.sv
module pe_enable_seq
   import pe_seq_pkg::*;
#(
   parameter int unsigned RST_PULSE_CYC = 4,
   parameter int unsigned SETTLE_CYC    = 40,
   parameter int unsigned HALF_CYC      = 3,
   parameter int unsigned MAX_TRIES     = 3,
   parameter int unsigned NBYTES        = 4,
   parameter int unsigned BW            = 8,
   parameter logic [NBYTES*BW-1:0] CMD  = 32'hAC53_0000,
   parameter int unsigned ECHO_IDX      = 2,
   parameter logic [BW-1:0] ECHO_VAL    = 8'h53,
   parameter bit          LSB_FIRST     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic miso,
   output logic tgt_reset,
   output logic sck,
   output logic mosi,
   output logic busy,
   output logic done,
   output logic fail
);

   localparam int unsigned MAXC = pe_max3(RST_PULSE_CYC, SETTLE_CYC, HALF_CYC);
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam int unsigned TW   = $clog2(MAX_TRIES + 1);

   generate
      if (RST_PULSE_CYC < 2) begin : g_bad_pulse
         $error("RST_PULSE_CYC must be at least 2");
      end
      if (SETTLE_CYC < 1 || HALF_CYC < 1) begin : g_bad_timing
         $error("SETTLE_CYC and HALF_CYC must be at least 1");
      end
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (NBYTES < 2 || BW < 2 || ECHO_IDX >= NBYTES) begin : g_bad_frame
         $error("frame shape parameters out of range");
      end
   endgenerate

   pe_state_e      st_q, st_d;
   logic [TW-1:0]  tries_q;
   logic           tries_clr, tries_inc;
   logic           tmr_load;
   logic [CW-1:0]  tmr_val;
   logic           tmr_zero;
   logic           sh_go, sh_tick, sh_last;
   logic [BW-1:0]  echo;
   logic           launchable;

   assign launchable = (st_q == PS_IDLE) || (st_q == PS_DONE) || (st_q == PS_FAIL);

   always_comb begin
      st_d      = st_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      sh_go     = 1'b0;
      sh_tick   = 1'b0;
      tries_clr = 1'b0;
      tries_inc = 1'b0;
      case (st_q)
         PS_IDLE, PS_DONE, PS_FAIL: begin
            if (start) begin
               st_d      = PS_PULSE;
               tmr_load  = 1'b1;
               tmr_val   = CW'(RST_PULSE_CYC - 1);
               tries_clr = 1'b1;
            end
         end
         PS_PULSE: begin
            if (tmr_zero) begin
               st_d     = PS_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = CW'(SETTLE_CYC - 1);
            end
         end
         PS_SETTLE: begin
            if (tmr_zero) begin
               st_d     = PS_XFER;
               tmr_load = 1'b1;
               tmr_val  = CW'(HALF_CYC - 1);
               sh_go    = 1'b1;
            end
         end
         PS_XFER: begin
            if (tmr_zero) begin
               sh_tick  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CW'(HALF_CYC - 1);
               if (sh_last) st_d = PS_CHECK;
            end
         end
         PS_CHECK: begin
            if (echo == ECHO_VAL) begin
               st_d = PS_DONE;
            end else if (tries_q == TW'(MAX_TRIES - 1)) begin
               st_d = PS_FAIL;
            end else begin
               st_d      = PS_PULSE;
               tmr_load  = 1'b1;
               tmr_val   = CW'(RST_PULSE_CYC - 1);
               tries_inc = 1'b1;
            end
         end
         default: st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_IDLE;
         tries_q <= '0;
      end else begin
         st_q <= st_d;
         if (tries_clr)      tries_q <= '0;
         else if (tries_inc) tries_q <= tries_q + 1'b1;
      end
   end

   pe_phase_timer #(.CW(CW)) timer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   pe_bit_shifter #(
      .NBYTES    (NBYTES),
      .BW        (BW),
      .ECHO_IDX  (ECHO_IDX),
      .LSB_FIRST (LSB_FIRST)
   ) shifter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (sh_go),
      .tick_i (sh_tick),
      .miso_i (miso),
      .cmd_i  (CMD),
      .sck_o  (sck),
      .mosi_o (mosi),
      .last_o (sh_last),
      .echo_o (echo)
   );

   assign tgt_reset = (st_q == PS_PULSE);
   assign busy      = !launchable;
   assign done      = (st_q == PS_DONE);
   assign fail      = (st_q == PS_FAIL);

   // R2: no serial activity while the target is held in its reset pulse
   a_r2_quiet_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_reset |-> (!sck && !mosi));

   // R7: a finished, matched sequence keeps the serial clock parked low
   a_r7_done_parks_clock: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!sck && !tgt_reset));

   // R9: a start request during a running attempt does not end it
   a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && st_q != PS_CHECK) |=> busy);

   // R8: the fail flag rises only when the retry budget is spent
   a_r8_fail_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> (tries_q == TW'(MAX_TRIES - 1)));

   // R6: the comparison cycle is entered only from a transfer
   a_r6_check_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PS_CHECK) |-> ($past(st_q) == PS_XFER));

endmodule

// File: tb/pe_enable_seq_tb_top.sv
module pe_enable_seq_tb_top;

   localparam int P    = 4;
   localparam int S    = 40;
   localparam int H    = 3;
   localparam int MAXT = 3;
   localparam logic [31:0] CMDW = 32'hAC53_0000;

   typedef struct packed {
      logic rst;
      logic sck;
      logic mosi;
      logic busy;
      logic done;
      logic fail;
   } obs_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic miso = 1'b0;
   logic tgt_reset, sck, mosi, busy, done, fail;

   always #2.5 clk = ~clk;

   pe_enable_seq #(
      .RST_PULSE_CYC (P),
      .SETTLE_CYC    (S),
      .HALF_CYC      (H),
      .MAX_TRIES     (MAXT)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .miso      (miso),
      .tgt_reset (tgt_reset),
      .sck       (sck),
      .mosi      (mosi),
      .busy      (busy),
      .done      (done),
      .fail      (fail)
   );

   int total = 0;
   int bad   = 0;
   int shown = 0;

   obs_t exp_q[$];
   obs_t exp_rest = '0;
   int   n_att_exp;

   logic [31:0] rep_list [0:7];
   logic [31:0] cur_rep = '0;
   int   att_seen  = 0;
   int   bitcnt    = 0;
   logic prev_sck  = 1'b0;
   logic prev_rst  = 1'b0;
   int   cyc       = 0;
   int   rises     = 0;
   int   fall_cyc  = -1;
   int   gap       = -1;

   task automatic chk(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         if (shown < 30) begin
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
            shown++;
         end
      end
   endtask

   // behavioural target: one reply word per attempt, shifted out on falling sck
   always @(negedge clk) begin
      cyc++;
      if (tgt_reset && !prev_rst) begin
         cur_rep = rep_list[att_seen];
         att_seen++;
      end
      if (tgt_reset) bitcnt = 0;
      else if (prev_sck && !sck) bitcnt++;
      miso = (bitcnt < 32) ? cur_rep[31 - bitcnt] : 1'b0;
      if (sck && !prev_sck) begin
         rises++;
         if (gap < 0 && fall_cyc >= 0) gap = cyc - fall_cyc;
      end
      if (!tgt_reset && prev_rst && fall_cyc < 0) fall_cyc = cyc;
      prev_sck = sck;
      prev_rst = tgt_reset;
   end

   function automatic obs_t mk(input logic r, input logic s, input logic m);
      obs_t o;
      o.rst = r; o.sck = s; o.mosi = m; o.busy = 1'b1; o.done = 1'b0; o.fail = 1'b0;
      return o;
   endfunction

   task automatic push_attempt();
      for (int i = 0; i < P; i++) exp_q.push_back(mk(1'b1, 1'b0, 1'b0));
      for (int i = 0; i < S; i++) exp_q.push_back(mk(1'b0, 1'b0, 1'b0));
      for (int by = 0; by < 4; by++) begin
         for (int bi = 7; bi >= 0; bi--) begin
            logic b;
            b = CMDW[(3 - by) * 8 + bi];
            for (int i = 0; i < H; i++) exp_q.push_back(mk(1'b0, 1'b0, b));
            for (int i = 0; i < H; i++) exp_q.push_back(mk(1'b0, 1'b1, b));
         end
      end
      exp_q.push_back(mk(1'b0, 1'b0, 1'b0));
   endtask

   task automatic build();
      logic ok;
      ok = 1'b0;
      n_att_exp = 0;
      for (int a = 0; a < MAXT; a++) begin
         push_attempt();
         n_att_exp++;
         if (rep_list[a][15:8] == 8'h53) begin
            ok = 1'b1;
            break;
         end
      end
      exp_rest = '0;
      exp_rest.done = ok;
      exp_rest.fail = !ok;
   endtask

   task automatic compare();
      obs_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else                  e = exp_rest;
      chk("R2 tgt_reset", int'(tgt_reset), int'(e.rst));
      chk("R5 sck",       int'(sck),       int'(e.sck));
      chk("R4 mosi",      int'(mosi),      int'(e.mosi));
      chk("R10 busy",     int'(busy),      int'(e.busy));
      chk("R7 done",      int'(done),      int'(e.done));
      chk("R8 fail",      int'(fail),      int'(e.fail));
   endtask

   task automatic tick(input logic st);
      @(negedge clk);
      compare();
      if (st && exp_q.size() == 0) build();
      start = st;
   endtask

   task automatic run_case(input logic [31:0] r0, input logic [31:0] r1,
                           input logic [31:0] r2, input bit poke);
      int i;
      rep_list[0] = r0; rep_list[1] = r1; rep_list[2] = r2;
      att_seen = 0; rises = 0; fall_cyc = -1; gap = -1;
      tick(1'b1);
      i = 0;
      while (exp_q.size() > 0) begin
         tick(poke && i == 100);
         if (poke && i == 101) begin
            // R9: the start raised mid-transfer did not re-pulse reset
            chk("R9 busy after ignored start", int'(busy), 1);
            chk("R9 no reset after ignored start", int'(tgt_reset), 0);
         end
         i++;
      end
      repeat (5) tick(1'b0);
      chk("R4 sck pulses per run", rises, 32 * n_att_exp);
      chk("R8 attempts made", att_seen, n_att_exp);
      chk("R3 reset fall to first sck rise", gap, S + H);
      chk("R6 outcome done", int'(done), int'(exp_rest.done));
      chk("R6 outcome fail", int'(fail), int'(exp_rest.fail));
   endtask

   initial begin
      for (int k = 0; k < 8; k++) rep_list[k] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs while reset is held
      chk("R1 tgt_reset in reset", int'(tgt_reset), 0);
      chk("R1 sck in reset",       int'(sck),       0);
      chk("R1 mosi in reset",      int'(mosi),      0);
      chk("R1 flags in reset",     int'({busy, done, fail}), 0);
      rst_n = 1'b1;
      repeat (4) tick(1'b0);
      // single attempt, echo correct
      run_case(32'h00AC_5300, 32'h0, 32'h0, 1'b0);
      // wrong echo then correct echo, with a start raised while busy
      run_case(32'h00AC_A500, 32'h00AC_5300, 32'h0, 1'b1);
      // every attempt wrong: retry limit reached
      run_case(32'h0000_0000, 32'hFFFF_52FF, 32'h00AC_5200, 1'b0);
      // restart from the failed state
      run_case(32'hFFFF_53FF, 32'h0, 32'h0, 1'b0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule